// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a four-bank single-data-rate SDRAM from reset until the memory can accept normal traffic. After reset is released it holds the bus at NOP for a power-up settling time set in microseconds and converted to clock cycles from the clock frequency. It then issues one precharge of all banks, two auto-refresh commands and one mode register load taken from a 10-bit configuration word. Each step is spaced by a programmable number of cycles. A sticky ready flag then tells the rest of the memory controller that it may take over the bus.

The command bus is the usual active-low chip select, row strobe, column strobe and write enable, plus a row/mode address bus and a bank select. An output-register option chooses between driving the pins straight from the sequencer state and adding one flop stage at the pins. The flop stage delays every event on the bus by one cycle. An asynchronous active-low reset restarts the whole sequence from the beginning at any point.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: During reset and on every cycle after reset release until the precharge, the bus shows NOP, meaning {cs_n,ras_n,cas_n,we_n} = 0111. The precharge first appears after rising edge number WAIT_CYC+L following reset release. WAIT_CYC is ceil(CLK_HZ/1000*WAIT_US/1000), which is 5000 at the defaults. L is 1 when REG_OUT=1 (the default) and 0 otherwise.
- R2: The precharge command is encoded 0010, drives address bit 10 high and every other address bit and the bank select low, and is issued exactly once.
- R3: The auto-refresh command is encoded 0001 with address and bank at zero. It is issued exactly twice: the first T_RP cycles after the precharge and the second T_RFC cycles after the first.
- R4: The mode load command is encoded 0000 and is issued once, T_RFC cycles after the second refresh, and only after the precharge and both refreshes. Its address carries mode_cfg[9:0] on bits 9..0: bits 2..0 burst length, bit 3 burst type, bits 6..4 read latency, bits 8..7 operating mode, bit 9 write burst mode. Bits 11 and up of the address are driven 0, and the bank select is 0.
- R5: On every cycle between and after these four commands the bus shows NOP, with address and bank at zero.
- R6: init_done is low until T_MRD cycles after the mode load command, rises on that cycle and then stays high until reset.
- R7: Asserting rst_n low at any point immediately forces NOP, zero address and bank, and init_done low. After release the full sequence, including the whole wait, runs again.
- R8: mode_cfg has no effect on the bus except on the mode load cycle. With REG_OUT=1 the value used is the one present at the edge that launches the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| mode_cfg | input | 10 | Mode word loaded into the memory's mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| ba | output | BANK_W | Bank select |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong count in the shared interval timer shows at the pins as a command that arrives one or more cycles early or late. The bench compares the bus on every cycle, so the error is caught on the very cycle the first misplaced command appears or fails to appear. A wrong state transition shows as a missing, repeated or reordered command, or as init_done rising at the wrong time or falling again, and is also caught on the first cycle the bus differs. A fault that leaks the configuration word or a stray address bit shows as a nonzero address on a NOP cycle, which the bench provokes by changing mode_cfg throughout the wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      S_WAIT,
      S_PRE,
      S_GAP_RP,
      S_REF1,
      S_GAP_RF1,
      S_REF2,
      S_GAP_RF2,
      S_LMR,
      S_GAP_MRD,
      S_DONE
   } init_state_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sdr_cmd_t;

   localparam sdr_cmd_t CMD_NOP = 4'b0111;
   localparam sdr_cmd_t CMD_PRE = 4'b0010;
   localparam sdr_cmd_t CMD_REF = 4'b0001;
   localparam sdr_cmd_t CMD_LMR = 4'b0000;

   localparam int MODE_W     = 10;
   localparam int ALLBANK_BIT = 10;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int CNT_W   = 13,
   parameter int RST_VAL = 4999
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic             zero
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= CNT_W'(RST_VAL);
      else if (ld)
         count_q <= ld_val;
      else if (count_q != '0)
         count_q <= count_q - 1'b1;
   end

   assign zero = (count_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int WAIT_CYC = 5000,
   parameter int T_RP     = 3,
   parameter int T_RFC    = 7,
   parameter int T_MRD    = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   output init_state_e state
);

   localparam int MAXV1 = (WAIT_CYC > T_RFC) ? WAIT_CYC : T_RFC;
   localparam int MAXV2 = (T_RP > T_MRD) ? T_RP : T_MRD;
   localparam int MAXV  = (MAXV1 > MAXV2) ? MAXV1 : MAXV2;
   localparam int CNT_W = $clog2(MAXV + 1);

   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
   localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);

   init_state_e      state_q, state_d;
   logic             tmr_ld, tmr_zero;
   logic [CNT_W-1:0] tmr_val;

   sdram_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (WAIT_CYC - 1)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (tmr_ld),
      .ld_val (tmr_val),
      .zero   (tmr_zero)
   );

   always_comb begin
      state_d = state_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      unique case (state_q)
         S_WAIT:    if (tmr_zero) state_d = S_PRE;
         S_PRE:     begin state_d = S_GAP_RP;  tmr_ld = 1'b1; tmr_val = LD_RP;  end
         S_GAP_RP:  if (tmr_zero) state_d = S_REF1;
         S_REF1:    begin state_d = S_GAP_RF1; tmr_ld = 1'b1; tmr_val = LD_RFC; end
         S_GAP_RF1: if (tmr_zero) state_d = S_REF2;
         S_REF2:    begin state_d = S_GAP_RF2; tmr_ld = 1'b1; tmr_val = LD_RFC; end
         S_GAP_RF2: if (tmr_zero) state_d = S_LMR;
         S_LMR:     begin state_d = S_GAP_MRD; tmr_ld = 1'b1; tmr_val = LD_MRD; end
         S_GAP_MRD: if (tmr_zero) state_d = S_DONE;
         S_DONE:    state_d = S_DONE;
         default:   state_d = S_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_WAIT;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // R1
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && !tmr_zero) |=> (state_q == S_WAIT));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int BANK_W  = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  init_state_e       state,
   input  logic [MODE_W-1:0] mode_cfg,
   output sdr_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba,
   output logic              done
);

   sdr_cmd_t          cmd_c;
   logic [ADDR_W-1:0] addr_c;
   logic [BANK_W-1:0] ba_c;
   logic              done_c;

   always_comb begin
      cmd_c  = CMD_NOP;
      addr_c = '0;
      ba_c   = '0;
      done_c = (state == S_DONE);
      case (state)
         S_PRE: begin
            cmd_c = CMD_PRE;
            addr_c[ALLBANK_BIT] = 1'b1;
         end
         S_REF1, S_REF2: cmd_c = CMD_REF;
         S_LMR: begin
            cmd_c = CMD_LMR;
            addr_c[MODE_W-1:0] = mode_cfg;
         end
         default: ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmd  <= CMD_NOP;
               addr <= '0;
               ba   <= '0;
               done <= 1'b0;
            end else begin
               cmd  <= cmd_c;
               addr <= addr_c;
               ba   <= ba_c;
               done <= done_c;
            end
         end
      end else begin : g_comb
         assign cmd  = cmd_c;
         assign addr = addr_c;
         assign ba   = ba_c;
         assign done = done_c;
      end
   endgenerate

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int CLK_HZ  = 50_000_000,
   parameter int WAIT_US = 100,
   parameter int T_RP    = 3,
   parameter int T_RFC   = 7,
   parameter int T_MRD   = 2,
   parameter int ADDR_W  = 13,
   parameter int BANK_W  = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [9:0]        mode_cfg,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba,
   output logic              init_done
);

   localparam int WAIT_CYC = ((CLK_HZ / 1000) * WAIT_US + 999) / 1000;

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must be at least 11");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("BANK_W must be at least 1");
      end
      if (T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_bad_gap
         $error("command spacings must be at least 2 cycles");
      end
      if (T_RP > 250 || T_RFC > 250) begin : g_bad_big
         $error("command spacings above 250 cycles unsupported");
      end
      if (WAIT_CYC < 2) begin : g_bad_wait
         $error("power-up wait must be at least 2 cycles");
      end
   endgenerate

   init_state_e state;
   sdr_cmd_t    bus_cmd;

   sdram_init_fsm #(
      .WAIT_CYC (WAIT_CYC),
      .T_RP     (T_RP),
      .T_RFC    (T_RFC),
      .T_MRD    (T_MRD)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state)
   );

   sdram_cmd_drive #(
      .ADDR_W  (ADDR_W),
      .BANK_W  (BANK_W),
      .REG_OUT (REG_OUT)
   ) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .mode_cfg (mode_cfg),
      .cmd      (bus_cmd),
      .addr     (addr),
      .ba       (ba),
      .done     (init_done)
   );

   assign {cs_n, ras_n, cas_n, we_n} = bus_cmd;

   // Bus observers used only by the checks below
   logic       pre_seen_q;
   logic [1:0] ref_seen_q;
   logic [7:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_seen_q <= 1'b0;
         ref_seen_q <= '0;
         since_q    <= '0;
      end else begin
         if (bus_cmd == CMD_PRE) pre_seen_q <= 1'b1;
         if (bus_cmd == CMD_REF && ref_seen_q != 2'd3) ref_seen_q <= ref_seen_q + 1'b1;
         if (bus_cmd != CMD_NOP)   since_q <= 8'd1;
         else if (since_q != 8'hFF) since_q <= since_q + 1'b1;
      end
   end

   // R3
   first_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_REF && ref_seen_q == 2'd0) |-> (since_q == 8'(T_RP)));

   // R3
   second_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_REF && ref_seen_q == 2'd1) |-> (since_q == 8'(T_RFC)));

   // R4
   mode_after_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_LMR) |-> (pre_seen_q && ref_seen_q == 2'd2 && since_q == 8'(T_RFC)));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

endmodule

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;

   localparam int CLK_HZ  = 50_000_000;
   localparam int WAIT_US = 100;
   localparam int T_RP    = 3;
   localparam int T_RFC   = 7;
   localparam int T_MRD   = 2;
   localparam int ADDR_W  = 13;
   localparam int BANK_W  = 2;
   localparam bit REG_OUT = 1'b1;

   localparam int W   = ((CLK_HZ / 1000) * WAIT_US + 999) / 1000;
   localparam int L   = REG_OUT ? 1 : 0;
   localparam int JP  = W + L;
   localparam int JR1 = JP + T_RP;
   localparam int JR2 = JR1 + T_RFC;
   localparam int JL  = JR2 + T_RFC;
   localparam int JD  = JL + T_MRD;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [9:0]        mode_cfg = '0;
   logic              cs_n, ras_n, cas_n, we_n, init_done;
   logic [ADDR_W-1:0] addr;
   logic [BANK_W-1:0] ba;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   sdram_pwrup_seq #(
      .CLK_HZ (CLK_HZ), .WAIT_US (WAIT_US), .T_RP (T_RP), .T_RFC (T_RFC),
      .T_MRD (T_MRD), .ADDR_W (ADDR_W), .BANK_W (BANK_W), .REG_OUT (REG_OUT)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .mode_cfg (mode_cfg),
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .addr (addr), .ba (ba), .init_done (init_done)
   );

   task automatic check_bus(input string tag, input logic [3:0] ecmd,
                            input logic [ADDR_W-1:0] eaddr, input logic [BANK_W-1:0] eba);
      checks++;
      if ({cs_n, ras_n, cas_n, we_n} !== ecmd || addr !== eaddr || ba !== eba) begin
         errors++;
         $display("FAIL %s cyc=%0d: got cmd=%b addr=%h ba=%0d, expected cmd=%b addr=%h ba=%0d",
                  tag, cyc, {cs_n, ras_n, cas_n, we_n}, addr, ba, ecmd, eaddr, eba);
      end
   endtask

   task automatic check_done(input string tag, input logic edone);
      checks++;
      if (init_done !== edone) begin
         errors++;
         $display("FAIL %s cyc=%0d: got init_done=%b, expected %b", tag, cyc, init_done, edone);
      end
   endtask

   task automatic hold_reset();
      rst_n = 1'b0;
      #1;
      check_bus("R7 reset bus", 4'b0111, '0, '0);
      check_done("R7 reset done", 1'b0);
      repeat (2) begin
         @(negedge clk);
         check_bus("R7 reset bus", 4'b0111, '0, '0);
         check_done("R7 reset done", 1'b0);
      end
      rst_n = 1'b1;
   endtask

   // j counts rising edges since reset release; sampled at the following falling edge
   task automatic run_seq(input logic [9:0] cfg, input bit wiggle, input int stop_at);
      int last;
      last = (stop_at > 0) ? stop_at : JD + 20;
      mode_cfg = wiggle ? 10'h2A5 : cfg;
      for (int j = 1; j <= last; j++) begin
         logic [3:0]        ecmd;
         logic [ADDR_W-1:0] eaddr;
         string             tag;
         @(posedge clk);
         @(negedge clk);
         ecmd  = 4'b0111;
         eaddr = '0;
         if (j < JP)       tag = wiggle ? "R1 R8 wait" : "R1 wait";
         else if (j == JP) begin tag = "R2 precharge"; ecmd = 4'b0010; eaddr[10] = 1'b1; end
         else if (j == JR1 || j == JR2) begin tag = "R3 refresh"; ecmd = 4'b0001; end
         else if (j == JL) begin tag = "R4 mode load"; ecmd = 4'b0000; eaddr[9:0] = cfg; end
         else              tag = wiggle ? "R5 R8 gap" : "R5 gap";
         check_bus(tag, ecmd, eaddr, '0);
         check_done("R6 done", (j >= JD));
         if (!wiggle || (j >= JL - 3 && j <= JL + 1)) mode_cfg = cfg;
         else mode_cfg = 10'((j * 37) ^ 341);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         errors++;
         checks++;
         $display("FAIL R5 watchdog: cycles=%0d, expected below %0d", cyc, 60000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      hold_reset();
      run_seq(10'h232, 1'b0, 0);
      // R7: abort in the middle of the refresh spacing, then restart
      hold_reset();
      run_seq(10'h0A9, 1'b1, JR1 + 2);
      hold_reset();
      run_seq(10'h3FF, 1'b1, 0);
      hold_reset();
      run_seq(10'h000, 1'b0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule